// File: doc/BRIEF.md
# Host Port Request/Acknowledge Controller

This block is the host-facing handshake of an 8-bit host port that couples an external host processor, or an external DMA controller, to an internal DSP core. One request output, `host_req_o`, carries two meanings that a mode bit selects. In interrupt mode it is a vectored interrupt line. While the host acknowledges a pending request, the block places a programmable vector byte on the host data bus. In DMA mode the same line is a transfer request. Each acknowledge writes the host data bus into a transmit byte register, and an internal byte counter picks that register, so the host address lines play no part.

The core side reaches the block through a plain synchronous register port. The core sets the control bits, loads the interrupt vector, writes a 16-bit receive word and reads back the 16-bit transmit word. The host strobes and the acknowledge input come from an unrelated clock domain. Each one passes through a two-flop synchroniser before it is used.

States of the request machine are `HP_IDLE` (no request), `HP_REQ` (request asserted), `HP_DMA_XFER` (DMA byte taken, request held low until the acknowledge is released) and `HP_VEC_OUT` (vector on the bus). The transitions are as follows. `HP_IDLE` goes to `HP_REQ` when the enabled condition is true. `HP_REQ` goes back to `HP_IDLE` when the condition clears or is masked. `HP_REQ` goes to `HP_DMA_XFER` on an acknowledge rising edge in DMA mode, and to `HP_VEC_OUT` on an acknowledge level in interrupt mode. `HP_DMA_XFER` goes to `HP_IDLE` once the acknowledge is released. `HP_VEC_OUT` goes to `HP_IDLE` when the acknowledge is released, when the condition clears, or when DMA mode is selected.

Top module: `hostport_handshake`

## Requirements
- R1: After reset, `host_req_o` and `host_doe_o` are low, the control word reads 0, TXDE is 1 and RXDF is 0.
- R2: A host read at host address 0 returns status with RXDF in bit 0 and TXDE in bit 1, and zeros in all other bits.
- R3: The request is asserted when (transmit enable and TXDE) or (receive enable, interrupt mode and RXDF) holds. The core control word (core address 0) carries transmit enable in bit 0, receive enable in bit 1, DMA mode in bit 2 and 16-bit DMA width in bit 3.
- R4: Clearing an enable bit drops `host_req_o`, including while a vector is being presented.
- R5: In interrupt mode, a host write of the high byte (host address 1) leaves TXDE set. A host write of the low byte (host address 2) clears TXDE. A host read of the high byte leaves RXDF set, and a host read of the low byte (host address 2) clears RXDF.
- R6: In interrupt mode, while a request is pending and the acknowledge is held, `host_doe_o` is high and `host_dout_o` equals the vector byte (core address 3). Without a pending request the acknowledge drives nothing.
- R7: In DMA mode the request follows transmit enable and TXDE. Each acknowledge rising edge takes one byte, and the request stays low until the acknowledge is released. An acknowledge with no request writes nothing.
- R8: In 16-bit DMA the first acknowledge fills the high byte and the second fills the low byte. Only the second clears TXDE, and the counter then returns to the high byte. In 8-bit DMA every acknowledge fills the low byte and clears TXDE.
- R9: A core read of the transmit word (core address 1) returns {high, low} and sets TXDE. A core write of the receive word (core address 2) sets RXDF, and the host reads its bytes at host addresses 1 and 2.
- R10: In DMA mode, host address writes change neither transmit byte nor TXDE.
- R11: An acknowledge change takes effect on the third rising clock edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_wr | input | 1 | Core register write strobe |
| core_rd | input | 1 | Core register read strobe |
| core_addr | input | 2 | Core register select |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data |
| host_rd_i | input | 1 | Asynchronous host read strobe |
| host_wr_i | input | 1 | Asynchronous host write strobe |
| host_addr_i | input | 2 | Host register select |
| host_din_i | input | 8 | Host data bus in |
| host_dout_o | output | 8 | Host data bus out |
| host_doe_o | output | 1 | High while the vector is driven |
| host_ack_i | input | 1 | Asynchronous acknowledge |
| host_req_o | output | 1 | Request to host or DMA controller |

## Verification
The hardest points to reach from the ports are the byte counter's wrap in 16-bit DMA and the exact cycle at which a synchronised acknowledge first takes effect. The bench drives two full acknowledge pulses and checks TXDE and the request after each one. It then reads the assembled word back through the core port, which shows that the high byte came first. It checks the counter reload by switching to 8-bit mode and confirming that the next byte lands low. For the latency, the acknowledge is raised between edges, the vector enable is checked low after two edges and high after the third, and masking during vector output is checked on its own.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
    typedef enum logic [1:0] {
        HP_IDLE,
        HP_REQ,
        HP_DMA_XFER,
        HP_VEC_OUT
    } hp_state_e;

    localparam int CTL_TX_EN = 0;
    localparam int CTL_RX_EN = 1;
    localparam int CTL_DMA   = 2;
    localparam int CTL_WIDE  = 3;
    localparam int CTL_BITS  = 4;

    localparam logic [1:0] CA_CTRL = 2'd0;
    localparam logic [1:0] CA_TXW  = 2'd1;
    localparam logic [1:0] CA_RXW  = 2'd2;
    localparam logic [1:0] CA_VEC  = 2'd3;

    localparam logic [1:0] HA_STAT = 2'd0;
    localparam logic [1:0] HA_HI   = 2'd1;
    localparam logic [1:0] HA_LO   = 2'd2;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign level_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/hp_regs.sv
module hp_regs
    import hostport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_wr,
    input  logic            core_rd,
    input  logic [1:0]      core_addr,
    input  logic [2*DW-1:0] core_wdata,
    output logic [2*DW-1:0] core_rdata,
    input  logic            host_wr_stb,
    input  logic            host_rd_stb,
    input  logic [1:0]      host_addr,
    input  logic [DW-1:0]   host_din,
    input  logic            dma_wr,
    output logic [DW-1:0]   host_rdata,
    output logic [DW-1:0]   vector,
    output logic            req_cond,
    output logic            dma_mode
);
    localparam int CW = 2 * DW;

    logic [CTL_BITS-1:0] ctrl_q;
    logic [DW-1:0]       tx_hi_q, tx_lo_q, rx_hi_q, rx_lo_q, vec_q;
    logic                txde_q, rxdf_q, cnt_lo_q;
    logic                wide;

    assign dma_mode = ctrl_q[CTL_DMA];
    assign wide     = ctrl_q[CTL_WIDE];
    assign vector   = vec_q;
    assign req_cond = (ctrl_q[CTL_TX_EN] & txde_q)
                    | (~dma_mode & ctrl_q[CTL_RX_EN] & rxdf_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            tx_hi_q  <= '0;
            tx_lo_q  <= '0;
            rx_hi_q  <= '0;
            rx_lo_q  <= '0;
            vec_q    <= '0;
            txde_q   <= 1'b1;
            rxdf_q   <= 1'b0;
            cnt_lo_q <= 1'b0;
        end else begin
            if (host_wr_stb && !dma_mode) begin
                if (host_addr == HA_HI) tx_hi_q <= host_din;
                if (host_addr == HA_LO) begin
                    tx_lo_q <= host_din;
                    txde_q  <= 1'b0;
                end
            end
            if (host_rd_stb && host_addr == HA_LO) rxdf_q <= 1'b0;
            if (dma_wr) begin
                if (wide && !cnt_lo_q) begin
                    tx_hi_q  <= host_din;
                    cnt_lo_q <= 1'b1;
                end else begin
                    tx_lo_q  <= host_din;
                    txde_q   <= 1'b0;
                    cnt_lo_q <= 1'b0;
                end
            end
            if (core_rd && core_addr == CA_TXW) txde_q <= 1'b1;
            if (core_wr) begin
                unique case (core_addr)
                    CA_CTRL: begin
                        ctrl_q   <= core_wdata[CTL_BITS-1:0];
                        cnt_lo_q <= 1'b0;
                    end
                    CA_RXW: begin
                        rx_hi_q <= core_wdata[CW-1:DW];
                        rx_lo_q <= core_wdata[DW-1:0];
                        rxdf_q  <= 1'b1;
                    end
                    CA_VEC:  vec_q <= core_wdata[DW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (core_addr)
            CA_CTRL: core_rdata = {{(CW-CTL_BITS){1'b0}}, ctrl_q};
            CA_TXW:  core_rdata = {tx_hi_q, tx_lo_q};
            CA_RXW:  core_rdata = {rx_hi_q, rx_lo_q};
            default: core_rdata = {{DW{1'b0}}, vec_q};
        endcase
    end

    always_comb begin
        unique case (host_addr)
            HA_STAT: host_rdata = {{(DW-2){1'b0}}, txde_q, rxdf_q};
            HA_HI:   host_rdata = rx_hi_q;
            HA_LO:   host_rdata = rx_lo_q;
            default: host_rdata = '0;
        endcase
    end

    assert_lo_byte_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && (!wide || cnt_lo_q) && !(core_rd && core_addr == CA_TXW)) |=> !txde_q);

    assert_rx_fill_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && core_addr == CA_RXW) |=> rxdf_q);

    assert_dma_host_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && host_wr_stb && !dma_wr && !core_wr) |=> ($stable(tx_hi_q) && $stable(tx_lo_q)));
endmodule

// File: rtl/hp_req_fsm.sv
module hp_req_fsm
    import hostport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_cond,
    input  logic dma_mode,
    input  logic ack_lvl,
    input  logic ack_rise,
    output logic req_o,
    output logic vec_on,
    output logic dma_wr
);
    hp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HP_IDLE: if (req_cond) state_d = HP_REQ;
            HP_REQ: begin
                if (!req_cond)                 state_d = HP_IDLE;
                else if (dma_mode && ack_rise) state_d = HP_DMA_XFER;
                else if (!dma_mode && ack_lvl) state_d = HP_VEC_OUT;
            end
            HP_DMA_XFER: if (!ack_lvl) state_d = HP_IDLE;
            HP_VEC_OUT:  if (!ack_lvl || !req_cond || dma_mode) state_d = HP_IDLE;
            default:     state_d = HP_IDLE;
        endcase
    end

    always_comb begin
        req_o  = (state_q == HP_REQ) || (state_q == HP_VEC_OUT);
        vec_on = (state_q == HP_VEC_OUT);
        dma_wr = (state_q == HP_REQ) && req_cond && dma_mode && ack_rise;
    end

    assert_drop_on_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !req_cond) |=> !req_o);

    assert_dma_ack_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |=> !req_o);

    assert_vec_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_on |-> ($past(ack_lvl) && !$past(dma_mode)));
endmodule

// File: rtl/hostport_handshake.sv
module hostport_handshake
    import hostport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        core_wr,
    input  logic        core_rd,
    input  logic [1:0]  core_addr,
    input  logic [15:0] core_wdata,
    output logic [15:0] core_rdata,
    input  logic        host_rd_i,
    input  logic        host_wr_i,
    input  logic [1:0]  host_addr_i,
    input  logic [7:0]  host_din_i,
    output logic [7:0]  host_dout_o,
    output logic        host_doe_o,
    input  logic        host_ack_i,
    output logic        host_req_o
);
    localparam int DW = 8;

    logic [2:0]    sync_lvl, sync_prev_q, sync_rise;
    logic [DW-1:0] host_rdata, vector;
    logic          req_cond, dma_mode, vec_on, dma_wr;

    hp_sync #(.N(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_ack_i, host_wr_i, host_rd_i}),
        .level_o (sync_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_prev_q <= '0;
        else        sync_prev_q <= sync_lvl;
    end
    assign sync_rise = sync_lvl & ~sync_prev_q;

    hp_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_wr     (core_wr),
        .core_rd     (core_rd),
        .core_addr   (core_addr),
        .core_wdata  (core_wdata),
        .core_rdata  (core_rdata),
        .host_wr_stb (sync_rise[1]),
        .host_rd_stb (sync_rise[0]),
        .host_addr   (host_addr_i),
        .host_din    (host_din_i),
        .dma_wr      (dma_wr),
        .host_rdata  (host_rdata),
        .vector      (vector),
        .req_cond    (req_cond),
        .dma_mode    (dma_mode)
    );

    hp_req_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_cond (req_cond),
        .dma_mode (dma_mode),
        .ack_lvl  (sync_lvl[2]),
        .ack_rise (sync_rise[2]),
        .req_o    (host_req_o),
        .vec_on   (vec_on),
        .dma_wr   (dma_wr)
    );

    assign host_doe_o  = vec_on;
    assign host_dout_o = vec_on ? vector : host_rdata;
endmodule

// File: tb/test_hostport_handshake.sv
`timescale 1ns/1ps
module test_hostport_handshake;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_wr = 1'b0, core_rd = 1'b0;
    logic [1:0]  core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_rdata;
    logic        host_rd_i = 1'b0, host_wr_i = 1'b0, host_ack_i = 1'b0;
    logic [1:0]  host_addr_i = '0;
    logic [7:0]  host_din_i = '0;
    logic [7:0]  host_dout_o;
    logic        host_doe_o, host_req_o;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hostport_handshake i_hostport_handshake (
        .clk(clk), .rst_n(rst_n),
        .core_wr(core_wr), .core_rd(core_rd), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .host_rd_i(host_rd_i), .host_wr_i(host_wr_i), .host_addr_i(host_addr_i),
        .host_din_i(host_din_i), .host_dout_o(host_dout_o), .host_doe_o(host_doe_o),
        .host_ack_i(host_ack_i), .host_req_o(host_req_o)
    );

    localparam logic [2:0] CW = 3'd0, CR = 3'd1, HW = 3'd2, HR = 3'd3, RQ = 3'd4, AK = 3'd5;
    localparam int NV = 49;
    // {op, requirement, address, data, expected}
    localparam logic [40:0] VEC [NV] = '{
        {HR, 4'd2,  2'd0, 16'h0000, 16'h0002}, // R2 status after reset
        {RQ, 4'd1,  2'd0, 16'h0000, 16'h0000}, // R1
        {CR, 4'd1,  2'd0, 16'h0000, 16'h0000}, // R1 control cleared
        {CW, 4'd3,  2'd0, 16'h0001, 16'h0000}, // R3 tx enable, interrupt mode
        {RQ, 4'd3,  2'd0, 16'h0000, 16'h0001}, // R3
        {CW, 4'd4,  2'd0, 16'h0000, 16'h0000}, // R4 mask
        {RQ, 4'd4,  2'd0, 16'h0000, 16'h0000}, // R4
        {CW, 4'd3,  2'd0, 16'h0001, 16'h0000},
        {HW, 4'd5,  2'd1, 16'h00AB, 16'h0000}, // R5 high byte
        {RQ, 4'd5,  2'd0, 16'h0000, 16'h0001}, // R5 still requesting
        {HW, 4'd5,  2'd2, 16'h00CD, 16'h0000}, // R5 low byte
        {RQ, 4'd5,  2'd0, 16'h0000, 16'h0000}, // R5 cleared
        {HR, 4'd2,  2'd0, 16'h0000, 16'h0000}, // R2 TXDE low
        {CR, 4'd9,  2'd1, 16'h0000, 16'hABCD}, // R9 assembled word
        {HR, 4'd9,  2'd0, 16'h0000, 16'h0002}, // R9 TXDE set again
        {RQ, 4'd9,  2'd0, 16'h0000, 16'h0001},
        {CW, 4'd3,  2'd0, 16'h0002, 16'h0000}, // R3 rx enable only
        {RQ, 4'd3,  2'd0, 16'h0000, 16'h0000},
        {CW, 4'd9,  2'd2, 16'h1234, 16'h0000}, // R9 core fills rx
        {RQ, 4'd3,  2'd0, 16'h0000, 16'h0001}, // R3 rx request
        {HR, 4'd2,  2'd0, 16'h0000, 16'h0003}, // R2 both flags
        {HR, 4'd9,  2'd1, 16'h0000, 16'h0012},
        {RQ, 4'd5,  2'd0, 16'h0000, 16'h0001}, // R5 high read keeps RXDF
        {HR, 4'd9,  2'd2, 16'h0000, 16'h0034},
        {RQ, 4'd5,  2'd0, 16'h0000, 16'h0000}, // R5 low read clears RXDF
        {HR, 4'd5,  2'd0, 16'h0000, 16'h0002},
        {CW, 4'd7,  2'd0, 16'h000D, 16'h0000}, // R7 16-bit DMA
        {RQ, 4'd7,  2'd0, 16'h0000, 16'h0001},
        {AK, 4'd8,  2'd0, 16'h0011, 16'h0000}, // R8 high byte
        {RQ, 4'd8,  2'd0, 16'h0000, 16'h0001},
        {HR, 4'd8,  2'd0, 16'h0000, 16'h0002},
        {AK, 4'd8,  2'd0, 16'h0022, 16'h0000}, // R8 low byte
        {RQ, 4'd8,  2'd0, 16'h0000, 16'h0000},
        {HR, 4'd8,  2'd0, 16'h0000, 16'h0000},
        {CR, 4'd8,  2'd1, 16'h0000, 16'h1122}, // R8 order
        {RQ, 4'd7,  2'd0, 16'h0000, 16'h0001},
        {HW, 4'd10, 2'd2, 16'h0099, 16'h0000}, // R10 ignored
        {HW, 4'd10, 2'd1, 16'h0088, 16'h0000}, // R10 ignored
        {HR, 4'd10, 2'd0, 16'h0000, 16'h0002},
        {CR, 4'd10, 2'd1, 16'h0000, 16'h1122},
        {CW, 4'd8,  2'd0, 16'h0005, 16'h0000}, // R8 8-bit DMA
        {AK, 4'd8,  2'd0, 16'h005A, 16'h0000},
        {RQ, 4'd8,  2'd0, 16'h0000, 16'h0000},
        {CR, 4'd8,  2'd1, 16'h0000, 16'h115A},
        {RQ, 4'd7,  2'd0, 16'h0000, 16'h0001},
        {CW, 4'd4,  2'd0, 16'h0004, 16'h0000}, // R4 DMA, tx disabled
        {RQ, 4'd4,  2'd0, 16'h0000, 16'h0000},
        {AK, 4'd7,  2'd0, 16'h0066, 16'h0000}, // R7 ack without request
        {CR, 4'd7,  2'd1, 16'h0000, 16'h115A}
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic core_write(input logic [1:0] a, input logic [15:0] d);
        core_addr = a; core_wdata = d; core_wr = 1'b1;
        wait_n(1); core_wr = 1'b0; wait_n(3);
    endtask

    task automatic core_read(input int req, input logic [1:0] a, input logic [15:0] e);
        core_addr = a; core_rd = 1'b1; #1;
        chk(req, core_rdata, e);
        wait_n(1); core_rd = 1'b0; wait_n(3);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        host_addr_i = a; host_din_i = d; host_wr_i = 1'b1;
        wait_n(4); host_wr_i = 1'b0; wait_n(4);
    endtask

    task automatic host_read(input int req, input logic [1:0] a, input logic [7:0] e);
        host_addr_i = a; #1;
        chk(req, {8'h00, host_dout_o}, {8'h00, e});
        host_rd_i = 1'b1; wait_n(4); host_rd_i = 1'b0; wait_n(4);
    endtask

    task automatic ack_pulse(input logic [7:0] d);
        host_din_i = d; host_ack_i = 1'b1;
        wait_n(6); host_ack_i = 1'b0; wait_n(6);
    endtask

    initial begin
        wait_n(3); rst_n = 1'b1; wait_n(2);
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            int          rq;
            logic [1:0]  ad;
            logic [15:0] dt, ex;
            {op, rq[3:0], ad, dt, ex} = {VEC[i][40:38], VEC[i][37:34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0]};
            rq = int'(VEC[i][37:34]);
            unique case (op)
                CW: core_write(ad, dt);
                CR: core_read(rq, ad, ex);
                HW: host_write(ad, dt[7:0]);
                HR: host_read(rq, ad, ex[7:0]);
                RQ: chk(rq, {15'd0, host_req_o}, ex);
                default: ack_pulse(dt[7:0]);
            endcase
        end

        // R7: request stays low while a DMA acknowledge is held
        core_write(2'd0, 16'h000D);
        chk(7, {15'd0, host_req_o}, 16'h1);
        host_din_i = 8'h3C; host_ack_i = 1'b1; wait_n(5);
        chk(7, {15'd0, host_req_o}, 16'h0);
        wait_n(5);
        chk(7, {15'd0, host_req_o}, 16'h0);
        host_ack_i = 1'b0; wait_n(6);
        chk(8, {15'd0, host_req_o}, 16'h1); // R8 only high byte taken

        // R1: reset mid-run
        rst_n = 1'b0; wait_n(3);
        chk(1, {14'd0, host_doe_o, host_req_o}, 16'h0);
        rst_n = 1'b1; wait_n(2);
        host_read(1, 2'd0, 8'h02);
        core_read(1, 2'd0, 16'h0000);

        // R6, R11: vector output and synchroniser latency
        core_write(2'd3, 16'h00C5);
        core_write(2'd0, 16'h0001);
        chk(3, {15'd0, host_req_o}, 16'h1);
        host_ack_i = 1'b1; wait_n(2);
        chk(11, {15'd0, host_doe_o}, 16'h0);
        wait_n(1);
        chk(11, {15'd0, host_doe_o}, 16'h1);
        chk(6, {8'h00, host_dout_o}, 16'h00C5);
        chk(6, {15'd0, host_req_o}, 16'h1);
        host_ack_i = 1'b0; wait_n(4);
        chk(6, {15'd0, host_doe_o}, 16'h0);

        // R4: masking while the vector is presented
        host_ack_i = 1'b1; wait_n(4);
        chk(4, {15'd0, host_doe_o}, 16'h1);
        core_write(2'd0, 16'h0000);
        chk(4, {14'd0, host_doe_o, host_req_o}, 16'h0);
        host_ack_i = 1'b0; wait_n(4);

        // R6: acknowledge without a pending request
        host_ack_i = 1'b1; wait_n(5);
        chk(6, {15'd0, host_doe_o}, 16'h0);
        host_ack_i = 1'b0; wait_n(4);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule